// File: doc/BRIEF.md
# Switchable Scan Segment Doorway Cell

This cell is a one-bit stage of a serial scan network that decides whether a downstream sub-segment is part of the active scan path. It holds two flops. The shift flop is always in the path and drives the serial output. The state flop holds the doorway setting. When the doorway is closed, serial data passes from the cell's input into the shift flop and does not enter the segment. When it is open, the segment's return data feeds the shift flop, so the segment is spliced into the path ahead of the cell's own bit.

Scan control in a network like this is shared. One clock and one set of shift, capture and update enables reach every cell. A cell acts on them only while its own select input is high. The segment enable output passes that gating on to the attached segment, and it is active only while the doorway is open.

To open the doorway, a 1 is shifted into the cell's bit and an update is then applied. A capture loads the present doorway setting into the shift flop, so the next shift reads that setting back. An asynchronous reset closes every cell.

Top module: `sib_cell`

## Requirements
- R1: While the active-low reset is low, and right after it is released, the serial output is 0 and the segment enable is 0 (closed).
- R2: With select high, the shift enable high, the capture enable low and the doorway closed, the shift flop (serial output) takes the serial input on the next rising clock. The segment return input is ignored.
- R3: With select high, the shift enable high, the capture enable low and the doorway open, the shift flop takes the segment return input on the next rising clock. The serial input is ignored.
- R4: The segment's serial input always carries the cell's serial input, whatever the state.
- R5: With select high and the update enable high, the state flop takes the shift flop's value at that clock edge (1 = open, 0 = closed).
- R6: The segment enable is high only when the doorway is open and select is high.
- R7: With select high and the capture enable high, the shift flop loads the doorway state (1 = open) on the next rising clock. Capture takes priority over shift.
- R8: With select low, the shift, capture and update enables have no effect. Both the serial output and the doorway state hold.
- R9: With select high and all enables low, the serial output holds while the serial input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared scan clock |
| rst_n | input | 1 | Asynchronous active-low reset; closes the cell |
| sel | input | 1 | Cell select; gates all enables |
| shift_en | input | 1 | Shared shift enable |
| cap_en | input | 1 | Shared capture enable |
| upd_en | input | 1 | Shared update enable |
| scan_in | input | 1 | Serial data from the upstream stage |
| scan_out | output | 1 | Serial data to the downstream stage (shift flop) |
| seg_scan_in | output | 1 | Serial data driven into the attached segment |
| seg_scan_ret | input | 1 | Serial data returned from the attached segment |
| seg_sel | output | 1 | Enable for the attached segment |

## Verification
A wrong doorway state shows at two ports. It appears on the segment enable in the first cycle after the faulty update. It also appears on the serial output one clock after the next shift, because the shift source is then the wrong one of the two inputs. A corrupted shift flop appears at the serial output at once. After a later update it also appears on the segment enable. Capturing the state makes the doorway setting visible at the serial output one clock after the capture, even with select-gated segments hiding the enable.

// File: rtl/sib_pkg.sv
package sib_pkg;
   typedef enum logic {
      SEG_CLOSED = 1'b0,
      SEG_OPEN   = 1'b1
   } seg_state_e;

   localparam int UPD_RISE = 0;
   localparam int UPD_FALL = 1;
endpackage

// File: rtl/sib_shift_stage.sv
module sib_shift_stage
   import sib_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       shift_en,
   input  logic       cap_en,
   input  seg_state_e door,
   input  logic       ser_in,
   input  logic       seg_ret,
   output logic       shift_q
);
   logic src_bit;
   logic shift_d;

   // open doorway: segment sits ahead of this bit
   assign src_bit = (door == SEG_OPEN) ? seg_ret : ser_in;

   always_comb begin
      shift_d = shift_q;
      if (sel && cap_en)
         shift_d = (door == SEG_OPEN);
      else if (sel && shift_en)
         shift_d = src_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= 1'b0;
      else        shift_q <= shift_d;
   end

   AST_CLOSED_TAKES_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shift_en && !cap_en && door == SEG_CLOSED) |=> shift_q == $past(ser_in)); // R2
   AST_OPEN_TAKES_RET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && shift_en && !cap_en && door == SEG_OPEN) |=> shift_q == $past(seg_ret)); // R3
   AST_CAPTURE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cap_en) |=> shift_q == ($past(door) == SEG_OPEN)); // R7
   AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && (cap_en || shift_en)) |=> $stable(shift_q)); // R8
endmodule

// File: rtl/sib_update_stage.sv
module sib_update_stage
   import sib_pkg::*;
#(
   parameter int UPD_EDGE = UPD_RISE
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       upd_en,
   input  logic       shift_q,
   output seg_state_e door
);
   logic       do_upd;
   seg_state_e door_d;

   assign do_upd = sel && upd_en;
   assign door_d = do_upd ? seg_state_e'(shift_q) : door;

   generate
      if (UPD_EDGE != UPD_RISE && UPD_EDGE != UPD_FALL) begin : g_bad_edge
         $error("sib_update_stage: UPD_EDGE must be UPD_RISE or UPD_FALL");
      end

      if (UPD_EDGE == UPD_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) door <= SEG_CLOSED;
            else        door <= door_d;
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) door <= SEG_CLOSED;
            else        door <= door_d;
         end

         AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel && upd_en) |=> door == seg_state_e'($past(shift_q))); // R5
         AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel && upd_en) |=> $stable(door)); // R8
      end
   endgenerate
endmodule

// File: rtl/sib_port_ctl.sv
module sib_port_ctl
   import sib_pkg::*;
(
   input  logic       sel,
   input  seg_state_e door,
   input  logic       ser_in,
   output logic       seg_in,
   output logic       seg_en
);
   assign seg_in = ser_in;
   assign seg_en = (door == SEG_OPEN) && sel;
endmodule

// File: rtl/sib_cell.sv
module sib_cell
   import sib_pkg::*;
#(
   parameter int UPD_EDGE = UPD_RISE
)(
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic shift_en,
   input  logic cap_en,
   input  logic upd_en,
   input  logic scan_in,
   output logic scan_out,
   output logic seg_scan_in,
   input  logic seg_scan_ret,
   output logic seg_sel
);
   seg_state_e door;
   logic       shift_q;

   sib_shift_stage u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .shift_en (shift_en),
      .cap_en   (cap_en),
      .door     (door),
      .ser_in   (scan_in),
      .seg_ret  (seg_scan_ret),
      .shift_q  (shift_q)
   );

   sib_update_stage #(.UPD_EDGE(UPD_EDGE)) u_update (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .upd_en  (upd_en),
      .shift_q (shift_q),
      .door    (door)
   );

   sib_port_ctl u_port (
      .sel    (sel),
      .door   (door),
      .ser_in (scan_in),
      .seg_in (seg_scan_in),
      .seg_en (seg_sel)
   );

   assign scan_out = shift_q;

   AST_SEG_SEL_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      seg_sel |-> sel); // R6
   AST_RESET_CLOSED: assert property (@(posedge clk)
      !rst_n |-> (!seg_sel && !scan_out)); // R1
endmodule

// File: tb/tb_sib_cell.sv
module tb_sib_cell;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0, shift_en = 1'b0, cap_en = 1'b0, upd_en = 1'b0;
   logic scan_in = 1'b0, seg_scan_ret = 1'b0;
   logic scan_out, seg_scan_in, seg_sel;
   int   n_checks = 0;
   int   n_errors = 0;

   always #2.5 clk = ~clk;

   sib_cell dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .shift_en(shift_en),
      .cap_en(cap_en), .upd_en(upd_en), .scan_in(scan_in),
      .scan_out(scan_out), .seg_scan_in(seg_scan_in),
      .seg_scan_ret(seg_scan_ret), .seg_sel(seg_sel)
   );

   task automatic check(string req, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ctl(logic s, logic sh, logic cp, logic up);
      sel = s; shift_en = sh; cap_en = cp; upd_en = up;
   endtask

   task automatic t_reset();
      #1;
      check("R1 scan_out in reset", scan_out, 1'b0);
      check("R1 seg_sel in reset", seg_sel, 1'b0);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check("R1 scan_out after reset", scan_out, 1'b0);
      check("R1 seg_sel after reset", seg_sel, 1'b0);
   endtask

   task automatic t_closed_shift();
      ctl(1, 1, 0, 0);
      scan_in = 1'b1; seg_scan_ret = 1'b0;
      #1 check("R4 seg_scan_in high", seg_scan_in, 1'b1);
      tick();
      check("R2 closed shift takes 1", scan_out, 1'b1);
      scan_in = 1'b0; seg_scan_ret = 1'b1;
      #1 check("R4 seg_scan_in low", seg_scan_in, 1'b0);
      tick();
      check("R2 closed shift takes 0", scan_out, 1'b0);
   endtask

   task automatic t_open();
      ctl(1, 1, 0, 0); scan_in = 1'b1; tick();
      ctl(1, 0, 0, 1); tick();
      ctl(1, 0, 0, 0);
      check("R5 update opens", seg_sel, 1'b1);
      check("R5 shift bit kept", scan_out, 1'b1);
      check("R6 seg_sel with sel", seg_sel, 1'b1);
   endtask

   task automatic t_open_shift();
      ctl(1, 1, 0, 0);
      scan_in = 1'b1; seg_scan_ret = 1'b0;
      #1 check("R4 seg_scan_in while open", seg_scan_in, 1'b1);
      tick();
      check("R3 open shift takes ret 0", scan_out, 1'b0);
      scan_in = 1'b0; seg_scan_ret = 1'b1; tick();
      check("R3 open shift takes ret 1", scan_out, 1'b1);
      ctl(1, 0, 0, 0);
   endtask

   task automatic t_capture();
      seg_scan_ret = 1'b0;
      ctl(1, 1, 0, 0); tick();
      check("R3 prep 0", scan_out, 1'b0);
      ctl(1, 1, 1, 0); tick();
      check("R7 capture open has priority", scan_out, 1'b1);
      ctl(1, 1, 0, 0); seg_scan_ret = 1'b0; tick();
      ctl(1, 0, 0, 1); tick();
      ctl(1, 0, 0, 0);
      check("R5 update closes", seg_sel, 1'b0);
      scan_in = 1'b1; ctl(1, 1, 0, 0); tick();
      check("R2 shift 1 before capture", scan_out, 1'b1);
      ctl(1, 0, 1, 0); tick();
      check("R7 capture closed", scan_out, 1'b0);
      ctl(1, 0, 0, 0);
   endtask

   task automatic t_deselect();
      scan_in = 1'b1; ctl(1, 1, 0, 0); tick();
      ctl(1, 0, 0, 1); tick();
      ctl(1, 0, 0, 0);
      check("R5 reopen", seg_sel, 1'b1);
      ctl(0, 0, 0, 0); #1;
      check("R6 seg_sel low without sel", seg_sel, 1'b0);
      scan_in = 1'b0; seg_scan_ret = 1'b0;
      ctl(0, 1, 0, 0); tick();
      check("R8 shift ignored", scan_out, 1'b1);
      ctl(0, 0, 1, 0); tick();
      ctl(0, 0, 0, 1); tick();
      ctl(0, 1, 1, 1); tick();
      check("R8 capture ignored", scan_out, 1'b1);
      ctl(1, 0, 0, 0); #1;
      check("R8 state held open", seg_sel, 1'b1);
   endtask

   task automatic t_hold();
      ctl(1, 0, 0, 0);
      scan_in = 1'b0; seg_scan_ret = 1'b0; tick(); tick();
      check("R9 hold no enables", scan_out, 1'b1);
      check("R9 state held", seg_sel, 1'b1);
   endtask

   initial begin
      t_reset();
      t_closed_shift();
      t_open();
      t_open_shift();
      t_capture();
      t_deselect();
      t_hold();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule